// File: doc/BRIEF.md
# Register Upset Detection Array

The block holds a bank of storage words that are never written during normal operation. When reset is asserted, the lower half of the bank is loaded with all ones and the upper half with all zeros. From then on each word is compared against the pattern it should still hold. Any bit that has risen in a zero word sets one flag. Any bit that has fallen in a one word sets a second flag. A test harness watches the two flags to spot upsets from radiation or from deliberate supply disturbance.

Both flags are registered and sticky. A flip that lasts only briefly is still reported to slow external monitoring, until reset reloads the patterns and clears the flags.

A self-test input lets the harness prove that the detection path works without a real fault. While it is held, every word is seen through an inverted view, so both flags rise. When it is released, the stored words are unchanged and the flags return low. The self-test view is never captured into the sticky state.

Top module: `ura_array`

## Requirements
- R1: While reset is held and after it is released, with no upset and no self-test, both up_flag_o and down_flag_o are 0. Reset loads words 0 to N_REGS/2-1 with all ones and the remaining words with all zeros.
- R2: A 0-to-1 change of any bit in a zero-loaded word sets up_flag_o at the next rising clock edge.
- R3: A 1-to-0 change of any bit in a one-loaded word sets down_flag_o at the next rising clock edge.
- R4: An upset of one direction does not raise the flag of the other direction.
- R5: Once set by an upset, a flag stays at 1 after the word returns to its loaded pattern.
- R6: While test_i is held at 1, both flags read 1 from the first rising edge after test_i rises.
- R7: After test_i falls, each flag returns to its captured upset state at the next rising edge: 0 if no upset was seen, 1 if one was seen.
- R8: Asserting rst_ni low clears both flags asynchronously and restores every word's pattern, so that the flags stay 0 after reset is released.
- R9: A single flipped bit is detected at either end of the word (bit 0 or bit WORD_W-1), in the first or the last word of either half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; loads the patterns and clears the flags |
| test_i | input | 1 | Self-test: presents the inverted view of every word to the detectors |
| up_flag_o | output | 1 | Sticky 0-to-1 upset flag, or self-test view |
| down_flag_o | output | 1 | Sticky 1-to-0 upset flag, or self-test view |

## Verification
The words are disturbed in several ways: a single low bit raised in the last zero word, a single top bit cleared in the first one word, and upsets of both directions at once. Taken together, these tell apart the two comparator polarities, the bank split and the bit ordering. Each upset is then undone, to separate a sticky capture from a live comparison. A self-test is run on a clean bank and again with one upset captured. This tells whether the override reaches both flags and whether it leaks into the sticky state. A reset that follows an upset shows that the patterns are reloaded, not merely that the flags are cleared.

// File: rtl/ura_pkg.sv
package ura_pkg;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_N_REGS = 16;
endpackage

// File: rtl/ura_cell.sv
module ura_cell #(
  parameter int unsigned WORD_W = ura_pkg::DEF_WORD_W,
  parameter bit          ONES   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_i,
  output logic raw_hit_o,
  output logic view_hit_o
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] view;

  // No functional write path: the word only holds its reset pattern
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= {WORD_W{ONES}};
    else         word_q <= word_q;
  end

  assign view = test_i ? ~word_q : word_q;

  generate
    if (ONES) begin : g_one
      assign raw_hit_o  = ~&word_q;
      assign view_hit_o = ~&view;
    end else begin : g_zero
      assign raw_hit_o  = |word_q;
      assign view_hit_o = |view;
    end
  endgenerate
endmodule

// File: rtl/ura_sticky.sv
module ura_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic view_i,
  output logic flag_o,
  output logic seen_o
);
  logic seen_q;
  logic view_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      view_q <= 1'b0;
    end else begin
      seen_q <= seen_q | raw_i;
      view_q <= view_i;
    end
  end

  assign flag_o = seen_q | view_q;
  assign seen_o = seen_q;
endmodule

// File: rtl/ura_array.sv
module ura_array #(
  parameter int unsigned WORD_W = ura_pkg::DEF_WORD_W,
  parameter int unsigned N_REGS = ura_pkg::DEF_N_REGS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_i,
  output logic up_flag_o,
  output logic down_flag_o
);
  localparam int unsigned HALF = N_REGS / 2;

  logic [N_REGS-1:0] raw_hit;
  logic [N_REGS-1:0] view_hit;
  logic up_raw, down_raw, up_view, down_view;
  logic up_seen, down_seen;

  for (genvar i = 0; i < N_REGS; i++) begin : g_cell
    ura_cell #(
      .WORD_W(WORD_W),
      .ONES  (i < HALF)
    ) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .test_i    (test_i),
      .raw_hit_o (raw_hit[i]),
      .view_hit_o(view_hit[i])
    );
  end

  assign down_raw  = |raw_hit[HALF-1:0];
  assign down_view = |view_hit[HALF-1:0];
  assign up_raw    = |raw_hit[N_REGS-1:HALF];
  assign up_view   = |view_hit[N_REGS-1:HALF];

  ura_sticky u_up (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (up_raw),
    .view_i(up_view),
    .flag_o(up_flag_o),
    .seen_o(up_seen)
  );

  ura_sticky u_down (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (down_raw),
    .view_i(down_view),
    .flag_o(down_flag_o),
    .seen_o(down_seen)
  );
endmodule

// File: rtl/ura_array_chk.sv
module ura_array_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic test_i,
  input logic up_flag_o,
  input logic down_flag_o,
  input logic up_raw,
  input logic down_raw,
  input logic up_seen,
  input logic down_seen
);
  p_test_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> (up_flag_o && down_flag_o));

  p_up_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_seen |=> up_seen);

  p_down_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_seen |=> down_seen);

  p_up_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_flag_o) |-> $past(test_i || up_raw));

  p_down_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(down_flag_o) |-> $past(test_i || down_raw));

  p_reset_clear_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (!up_flag_o && !down_flag_o));
endmodule

bind ura_array ura_array_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .test_i     (test_i),
  .up_flag_o  (up_flag_o),
  .down_flag_o(down_flag_o),
  .up_raw     (up_raw),
  .down_raw   (down_raw),
  .up_seen    (up_seen),
  .down_seen  (down_seen)
);

// File: tb/ura_array_bench.sv
`timescale 1ns/1ps
module ura_array_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test = 1'b0;
  logic up_f, down_f;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  typedef struct {
    logic  up;
    logic  dn;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  ura_array u_ura_array (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .test_i     (test),
    .up_flag_o  (up_f),
    .down_flag_o(down_f)
  );

  task automatic check(input logic up, input logic dn, input string tag);
    n_checks++;
    if (up_f !== up || down_f !== dn) begin
      n_errors++;
      $display("FAIL %s: up=%b down=%b expected up=%b down=%b", tag, up_f, down_f, up, dn);
    end
  endtask

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.up, e.dn, e.tag);
    end
  end

  // Driver: let one rising edge pass, then queue the expected flags
  task automatic step(input logic up, input logic dn, input string tag);
    exp_t e;
    @(posedge clk);
    e.up = up; e.dn = dn; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check(1'b0, 1'b0, "R8 flags low during reset");
    @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #1 check(1'b0, 1'b0, "R1 flags low in reset");
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    step(1'b0, 1'b0, "R1 clean after reset");
    step(1'b0, 1'b0, "R1 clean hold");

    test = 1'b1;
    step(1'b1, 1'b1, "R6 self-test raises both");
    step(1'b1, 1'b1, "R6 self-test held");
    test = 1'b0;
    step(1'b0, 1'b0, "R7 release clean bank");
    step(1'b0, 1'b0, "R7 self-test not captured");

    // Bit 0 raised in the last zero word
    force u_ura_array.g_cell[15].u_cell.word_q = 32'h0000_0001;
    release u_ura_array.g_cell[15].u_cell.word_q;
    step(1'b1, 1'b0, "R2 R4 r9_ low bit up upset");
    force u_ura_array.g_cell[15].u_cell.word_q = 32'h0000_0000;
    release u_ura_array.g_cell[15].u_cell.word_q;
    step(1'b1, 1'b0, "R5 up flag sticky");

    do_reset();
    step(1'b0, 1'b0, "R8 restored after up upset");
    step(1'b0, 1'b0, "R8 stays clean");

    // Bit 31 cleared in the first one word
    force u_ura_array.g_cell[0].u_cell.word_q = 32'h7FFF_FFFF;
    release u_ura_array.g_cell[0].u_cell.word_q;
    step(1'b0, 1'b1, "R3 R4 r9_ top bit down upset");
    force u_ura_array.g_cell[0].u_cell.word_q = 32'hFFFF_FFFF;
    release u_ura_array.g_cell[0].u_cell.word_q;
    step(1'b0, 1'b1, "R5 down flag sticky");

    test = 1'b1;
    step(1'b1, 1'b1, "R6 self-test with captured upset");
    test = 1'b0;
    step(1'b0, 1'b1, "R7 release keeps captured down");

    do_reset();
    step(1'b0, 1'b0, "R8 restored after down upset");

    // Both halves at once: top bit of first zero word, bit 0 of last one word
    force u_ura_array.g_cell[8].u_cell.word_q = 32'h8000_0000;
    force u_ura_array.g_cell[7].u_cell.word_q = 32'hFFFF_FFFE;
    release u_ura_array.g_cell[8].u_cell.word_q;
    release u_ura_array.g_cell[7].u_cell.word_q;
    step(1'b1, 1'b1, "R9 boundary words both directions");

    do_reset();
    step(1'b0, 1'b0, "R8 final reset clean");

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule